// File: doc/BRIEF.md
# Double-Buffered Serial Receive Queue

This block sits behind a serial receiver and collects incoming 9-bit data frames into a 16-entry store. The store is split into a lower half (entries 0 to 7) and an upper half (entries 8 to 15). When the last entry of a half is written, a per-half full flag rises. Each flag can also raise its own interrupt. Software drains one half while the receiver keeps filling the other, and then acknowledges the flag.

Frames arrive on a valid/ready stream. They come with framing-error, parity-error and noise qualifiers, plus separate idle-line and receiver-overrun pulses. The block never applies back-pressure: `frm_ready` is held high. A frame offered while the queue cannot take it is rejected or flagged in the same cycle, never stalled. The receiver upstream therefore needs no buffering.

A simple register port gives software access to the block. Through it software reads and writes the control word, reads the status word and the write pointer, and reads the entries. While the queue is disabled, software may also write the entries as general-purpose storage. Flags are acknowledged by read-then-write or read-then-read sequences, so a stale write cannot discard an event that software has not yet seen.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset the control word, the status word, the write pointer and both interrupt outputs are zero, and `frm_ready` is 1.
- R2: An accepted frame is written to the entry addressed by the write pointer (register addresses 0 to 15 read entries 0 to 15). The pointer then increments and wraps from 15 to 0.
- R3: Storing into entry 7 sets the lower-half flag (status bit 0). Storing into entry 15 sets the upper-half flag (status bit 1). After 16 clean frames both flags are set, bits 2 to 5 are clear, and the pointer (address 18) reads 0.
- R4: `irq_low` equals status bit 0 AND control bit 2, and `irq_high` equals status bit 1 AND control bit 3.
- R5: Status bits 0 to 5 clear only when a write of 0 to the bit at address 17 follows a read of address 17 that returned that bit set. A write of 0 without that read leaves the bit set.
- R6: A frame with a framing or parity error sets status bit 3 or bit 4 respectively. It is not stored and leaves the pointer unchanged. While either bit is set no frame is stored; once both are cleared, storing resumes at the same entry.
- R7: A clean frame whose target half has its full flag set sets status bit 2 and clears control bit 0. It is not stored and does not move the pointer.
- R8: A frame is stored only when control bit 0 (queue enable) and bit 1 (receiver enable) are set and status bits 2 (queue overrun), 3, 4 and 5 (receiver overrun, set by `rx_overrun`) are all clear.
- R9: A stored frame marked with noise sets status bit 6, and an idle pulse sets status bit 7. Each clears only when a read of any entry follows a status read that returned it set.
- R10: Writing control bit 0 from 0 to 1 resets the write pointer to 0.
- R11: A register write to an entry address changes the entry only while control bit 0 is clear.
- R12: `frm_ready` is 1 in every cycle; a rejected frame is consumed, not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame offered this cycle |
| frm_ready | output | 1 | Always 1; the block takes every offered frame |
| frm_data | input | 9 | Frame payload |
| frm_ferr | input | 1 | Frame has a framing error |
| frm_perr | input | 1 | Frame has a parity error |
| frm_noise | input | 1 | Frame was sampled with noise |
| line_idle | input | 1 | Idle-line pulse from the receiver |
| rx_overrun | input | 1 | Receiver lost a frame upstream |
| reg_addr | input | 5 | Register address: 0-15 entries, 16 control, 17 status, 18 pointer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the clear sequences) |
| reg_wdata | input | 9 | Register write data |
| reg_rdata | output | 9 | Register read data for `reg_addr`, combinational |
| irq_low | output | 1 | Lower-half interrupt |
| irq_high | output | 1 | Upper-half interrupt |

## Verification
The hardest state to reach is a queue overrun. Both half flags must stay set while a further clean frame arrives, and the pointer must sit at an entry whose half is still full. The bench gets there with a complete 16-frame fill that is never acknowledged. It offers one more frame, and only then runs the read-then-write clear, with a bare write first to show that it alone is refused. The frozen-pointer case is reached in the same way: a half-filled queue takes an error frame, and the bench then shows that a clean frame is blocked until the error bits are acknowledged.

// File: rtl/srq_pkg.sv
package srq_pkg;
  // status word bit positions (software-visible)
  localparam int SB_LOW  = 0;
  localparam int SB_HIGH = 1;
  localparam int SB_QOVR = 2;
  localparam int SB_FERR = 3;
  localparam int SB_PERR = 4;
  localparam int SB_ROVR = 5;
  localparam int SB_NOIS = 6;
  localparam int SB_IDLE = 7;
  localparam int STAT_W  = 8;
  localparam int WCLR_N  = 6;  // bits acknowledged by read-then-write

  typedef struct packed {
    logic high_ie;
    logic low_ie;
    logic rx_en;
    logic q_en;
  } ctrl_t;
endpackage

// File: rtl/srq_regif.sv
module srq_regif #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int ADDR_W = PTR_W + 1
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] entry_q,
  input  srq_pkg::ctrl_t    ctrl,
  input  logic [srq_pkg::STAT_W-1:0] stat,
  input  logic [PTR_W-1:0]  ptr,
  output logic              wr_entry,
  output logic              rd_entry,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic              rd_stat,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(DEPTH + 2);

  logic in_queue;
  assign in_queue = (reg_addr < A_CTRL);
  assign wr_entry = reg_wr & in_queue;
  assign rd_entry = reg_rd & in_queue;
  assign wr_ctrl  = reg_wr & (reg_addr == A_CTRL);
  assign wr_stat  = reg_wr & (reg_addr == A_STAT);
  assign rd_stat  = reg_rd & (reg_addr == A_STAT);

  always_comb begin
    rdata = '0;
    if (in_queue)               rdata = entry_q;
    else if (reg_addr == A_CTRL) rdata = DATA_W'(ctrl);
    else if (reg_addr == A_STAT) rdata = DATA_W'(stat);
    else if (reg_addr == A_PTR)  rdata = DATA_W'(ptr);
  end
endmodule

// File: rtl/srq_store.sv
module srq_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_en,
  input  logic [DATA_W-1:0] store_data,
  input  logic              reinit,
  input  logic              gp_wr,
  input  logic [PTR_W-1:0]  gp_idx,
  input  logic [DATA_W-1:0] gp_data,
  output logic [DATA_W-1:0] entry_q,
  output logic [PTR_W-1:0]  ptr
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                                  mem[g] <= '0;
      else if (store_en && ptr == PTR_W'(g))       mem[g] <= store_data;
      else if (gp_wr && gp_idx == PTR_W'(g))       mem[g] <= gp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr <= '0;
    else if (reinit)   ptr <= '0;
    else if (store_en) ptr <= ptr + 1'b1;
  end

  assign entry_q = mem[gp_idx];

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && ptr == PTR_W'(DEPTH - 1)) |=> (ptr == '0)); // R2
  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && ptr == '0) |=> (mem[0] == $past(store_data))); // R2
endmodule

// File: rtl/srq_flags.sv
module srq_flags #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int HALF  = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic              frm_ferr,
  input  logic              frm_perr,
  input  logic              frm_noise,
  input  logic              line_idle,
  input  logic              rx_overrun,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic              rd_stat,
  input  logic              rd_entry,
  input  logic [3:0]        wbits_ctrl,
  input  logic [srq_pkg::STAT_W-1:0] wbits_stat,
  output srq_pkg::ctrl_t    ctrl,
  output logic [srq_pkg::STAT_W-1:0] stat,
  output logic              store_en,
  output logic              reinit,
  output logic              irq_low,
  output logic              irq_high
);
  import srq_pkg::*;

  logic [STAT_W-1:0] arm, set_v, clr_v;
  logic frame_in, bad, q_open, attempt, tgt_full, ovf;

  assign frame_in = frm_valid & ctrl.rx_en;
  assign bad      = frm_ferr | frm_perr;
  assign q_open   = ctrl.q_en & ctrl.rx_en & ~stat[SB_QOVR] & ~stat[SB_FERR]
                  & ~stat[SB_PERR] & ~stat[SB_ROVR];
  assign tgt_full = ptr[PTR_W-1] ? stat[SB_HIGH] : stat[SB_LOW];
  assign attempt  = frm_valid & q_open & ~bad;
  assign store_en = attempt & ~tgt_full;
  assign ovf      = attempt & tgt_full;
  assign reinit   = wr_ctrl & wbits_ctrl[0] & ~ctrl.q_en;

  always_comb begin
    set_v          = '0;
    set_v[SB_LOW]  = store_en & (ptr == PTR_W'(HALF - 1));
    set_v[SB_HIGH] = store_en & (ptr == PTR_W'(DEPTH - 1));
    set_v[SB_QOVR] = ovf;
    set_v[SB_FERR] = frame_in & frm_ferr;
    set_v[SB_PERR] = frame_in & frm_perr;
    set_v[SB_ROVR] = rx_overrun & ctrl.rx_en;
    set_v[SB_NOIS] = store_en & frm_noise;
    set_v[SB_IDLE] = line_idle & ctrl.rx_en;
    for (int i = 0; i < STAT_W; i++) begin
      if (i < WCLR_N) clr_v[i] = wr_stat & arm[i] & ~wbits_stat[i];
      else            clr_v[i] = rd_entry & arm[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      arm  <= '0;
    end else begin
      stat <= (stat & ~clr_v) | set_v;
      if (rd_stat) arm <= stat;
      else begin
        if (wr_stat)  arm[WCLR_N-1:0]      <= '0;
        if (rd_entry) arm[STAT_W-1:WCLR_N] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl <= '0;
    else begin
      if (wr_ctrl)    ctrl <= ctrl_t'(wbits_ctrl);
      if (ovf)        ctrl.q_en <= 1'b0;
    end
  end

  assign irq_low  = stat[SB_LOW]  & ctrl.low_ie;
  assign irq_high = stat[SB_HIGH] & ctrl.high_ie;

  AST_LOW_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && ptr == PTR_W'(HALF - 1)) |=> stat[SB_LOW]); // R3
  AST_QOVR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[SB_QOVR]) |-> !ctrl.q_en); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_low |-> ctrl.low_ie) and (irq_high |-> ctrl.high_ie)); // R4
  AST_STORE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> (ctrl.q_en && ctrl.rx_en)); // R8
  AST_NO_BARE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rd_stat) && $past(!arm[SB_LOW]) && $past(stat[SB_LOW])) |-> stat[SB_LOW]); // R5
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int ADDR_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_ferr,
  input  logic              frm_perr,
  input  logic              frm_noise,
  input  logic              line_idle,
  input  logic              rx_overrun,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_low,
  output logic              irq_high
);
  import srq_pkg::*;

  ctrl_t             ctrl;
  logic [STAT_W-1:0] stat;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] entry_q;
  logic wr_entry, rd_entry, wr_ctrl, wr_stat, rd_stat, store_en, reinit;

  assign frm_ready = 1'b1;

  srq_regif #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regif (
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .entry_q(entry_q), .ctrl(ctrl), .stat(stat), .ptr(ptr),
    .wr_entry(wr_entry), .rd_entry(rd_entry), .wr_ctrl(wr_ctrl),
    .wr_stat(wr_stat), .rd_stat(rd_stat), .rdata(reg_rdata)
  );

  srq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_ferr(frm_ferr), .frm_perr(frm_perr),
    .frm_noise(frm_noise), .line_idle(line_idle), .rx_overrun(rx_overrun),
    .ptr(ptr), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .rd_stat(rd_stat),
    .rd_entry(rd_entry), .wbits_ctrl(reg_wdata[3:0]),
    .wbits_stat(reg_wdata[STAT_W-1:0]),
    .ctrl(ctrl), .stat(stat), .store_en(store_en), .reinit(reinit),
    .irq_low(irq_low), .irq_high(irq_high)
  );

  srq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .store_en(store_en), .store_data(frm_data), .reinit(reinit),
    .gp_wr(wr_entry & ~ctrl.q_en), .gp_idx(reg_addr[PTR_W-1:0]),
    .gp_data(reg_wdata), .entry_q(entry_q), .ptr(ptr)
  );

  AST_ERR_FREEZES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && (frm_ferr || frm_perr) && !(reg_wr && reg_addr == ADDR_W'(DEPTH)))
      |=> $stable(ptr)); // R6
  AST_REINIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(DEPTH) && reg_wdata[0] && !ctrl.q_en) |=> (ptr == '0)); // R10
endmodule

// File: tb/tb_serial_rx_queue.sv
module tb_serial_rx_queue;
  localparam int A_CTRL = 16, A_STAT = 17, A_PTR = 18;

  logic clk = 0, rst_n = 0;
  logic frm_valid = 0, frm_ferr = 0, frm_perr = 0, frm_noise = 0;
  logic line_idle = 0, rx_overrun = 0;
  logic [8:0] frm_data = '0;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic frm_ready, irq_low, irq_high;

  int checks = 0, errors = 0;
  logic [8:0] exp_mem [16];
  logic [8:0] v;

  serial_rx_queue dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 53 + 17) % 512);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input logic [8:0] d, input logic fe, input logic pe, input logic nf);
    @(negedge clk);
    frm_valid = 1; frm_data = d; frm_ferr = fe; frm_perr = pe; frm_noise = nf;
    @(negedge clk);
    frm_valid = 0; frm_ferr = 0; frm_perr = 0; frm_noise = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = 5'(a); reg_wdata = 9'(d); reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [8:0] q);
    @(negedge clk); reg_addr = 5'(a); reg_rd = 1; #1 q = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(input int a, output logic [8:0] q);
    @(negedge clk); reg_addr = 5'(a); #1 q = reg_rdata;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R12 reset state
    peek(A_STAT, v); chk("R1 status", v, 0);
    peek(A_CTRL, v); chk("R1 ctrl", v, 0);
    peek(A_PTR, v);  chk("R1 ptr", v, 0);
    chk("R1 irq", {irq_high, irq_low}, 0);
    chk("R12 ready", frm_ready, 1);

    // R8 gating sweep over the two enables
    for (int c = 0; c < 3; c++) begin
      wr(A_CTRL, c);
      frame(9'h55, 0, 0, 0);
      peek(A_PTR, v); chk("R8 closed ptr", v, 0);
      wr(A_CTRL, 0);
    end

    // R2 / R3 full fill
    wr(A_CTRL, 3);
    for (int i = 0; i < 16; i++) begin
      frame(pat(i), 0, 0, 0);
      exp_mem[i] = pat(i);
      chk("R12 ready", frm_ready, 1);
      peek(A_PTR, v); chk("R2 ptr step", v, (i + 1) % 16);
      peek(A_STAT, v);
      chk("R3 half flags", v[1:0], (i >= 15) ? 3 : (i >= 7) ? 1 : 0);
    end
    peek(A_STAT, v); chk("R3 full fill status", v, 3);
    for (int i = 0; i < 16; i++) begin
      peek(i, v); chk("R2 entry", v, exp_mem[i]);
    end

    // R4 interrupt enable sweep
    for (int ie = 0; ie < 4; ie++) begin
      wr(A_CTRL, 3 | (ie << 2));
      chk("R4 irq_low", irq_low, ie & 1);
      chk("R4 irq_high", irq_high, (ie >> 1) & 1);
    end

    // R7 overrun into full lower half
    frame(9'h1F0, 0, 0, 0);
    peek(A_STAT, v); chk("R7 qovr", v[2], 1);
    peek(A_CTRL, v); chk("R7 q_en cleared", v[0], 0);
    peek(A_PTR, v);  chk("R7 ptr held", v, 0);
    peek(0, v);      chk("R7 entry untouched", v, exp_mem[0]);

    // R5 bare write refused, then read-then-write clears
    wr(A_STAT, 0);
    peek(A_STAT, v); chk("R5 bare write", v, 7);
    rd(A_STAT, v);   chk("R5 read sees", v, 7);
    wr(A_STAT, 9'h002);  // keep bit1, clear bits 0 and 2
    peek(A_STAT, v); chk("R5 partial clear", v, 2);
    rd(A_STAT, v); wr(A_STAT, 0);
    peek(A_STAT, v); chk("R5 cleared", v, 0);

    // R10 rising edge of queue enable resets pointer
    wr(A_CTRL, 3);
    for (int i = 0; i < 3; i++) begin
      frame(pat(20 + i), 0, 0, 0); exp_mem[i] = pat(20 + i);
    end
    peek(A_PTR, v); chk("R10 pre", v, 3);
    wr(A_CTRL, 3);
    peek(A_PTR, v); chk("R10 no edge", v, 3);
    wr(A_CTRL, 2); wr(A_CTRL, 3);
    peek(A_PTR, v); chk("R10 edge", v, 0);

    // R6 error frames
    frame(pat(30), 0, 0, 0); exp_mem[0] = pat(30);
    frame(pat(31), 0, 0, 0); exp_mem[1] = pat(31);
    frame(9'h0AA, 1, 0, 0);
    peek(A_STAT, v); chk("R6 ferr flag", v[3], 1);
    peek(A_PTR, v);  chk("R6 ptr frozen", v, 2);
    frame(9'h0BB, 0, 1, 0);
    frame(9'h0CC, 0, 0, 0);
    peek(A_STAT, v); chk("R6 perr flag", v[4], 1);
    peek(A_PTR, v);  chk("R6 blocked ptr", v, 2);
    peek(2, v);      chk("R6 entry untouched", v, exp_mem[2]);
    rd(A_STAT, v); wr(A_STAT, 0);
    frame(pat(32), 0, 0, 0); exp_mem[2] = pat(32);
    peek(2, v);      chk("R6 resumes at entry", v, exp_mem[2]);
    peek(A_PTR, v);  chk("R6 resume ptr", v, 3);

    // R8 receiver overrun blocks storage
    @(negedge clk); rx_overrun = 1; @(negedge clk); rx_overrun = 0;
    frame(9'h0DD, 0, 0, 0);
    peek(A_STAT, v); chk("R8 rovr flag", v[5], 1);
    peek(A_PTR, v);  chk("R8 rovr blocks", v, 3);
    rd(A_STAT, v); wr(A_STAT, 0);

    // R9 noise and idle
    frame(pat(40), 0, 0, 1); exp_mem[3] = pat(40);
    peek(3, v);      chk("R9 noisy stored", v, exp_mem[3]);
    peek(A_STAT, v); chk("R9 noise flag", v[6], 1);
    rd(5, v);
    peek(A_STAT, v); chk("R9 noise kept", v[6], 1);
    rd(A_STAT, v); rd(0, v);
    peek(A_STAT, v); chk("R9 noise cleared", v[6], 0);
    @(negedge clk); line_idle = 1; @(negedge clk); line_idle = 0;
    peek(A_STAT, v); chk("R9 idle flag", v[7], 1);
    rd(A_STAT, v); rd(1, v);
    peek(A_STAT, v); chk("R9 idle cleared", v[7], 0);

    // R11 general-purpose entry writes
    wr(5, 9'h1AA);
    peek(5, v); chk("R11 enabled ignores", v, exp_mem[5]);
    wr(A_CTRL, 2);
    wr(5, 9'h1AA);
    peek(5, v); chk("R11 disabled writes", v, 9'h1AA);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule